// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Code Register Bank

This block sits behind a serial command receiver and turns each completed 24-bit command word into register updates for two output channels, A and B. Each channel keeps a staging buffer and a live output register. Both hold a 16-bit code and a 2-bit power mode. A command can write one staging buffer and, in the same step, copy either or both staging buffers into their live registers. Both channels can therefore be changed together or one after the other.

The top byte of the command word is the control field, and the low 16 bits carry the code. The power mode travels through the same staging-then-load path as the code. A channel's live mode therefore changes only when that channel is loaded. The live codes, live modes and a one-cycle update pulse per channel drive the conversion stage that follows.

Top module: `dual_chan_regbank`

## Requirements
- R1: After reset both live codes are 0, both live modes are 00 (normal), and both update pulses and the error pulse are low.
- R2: An accepted command writes bits 15:0 (code) and bits 17:16 (mode) into the staging buffer chosen by bit 18 (0 = channel A, 1 = channel B). The code bits are stored as given even when the mode is nonzero.
- R3: Bit 20 set copies channel A's staging buffer into A's live register, and bit 21 set does the same for channel B. The copy includes any staging write made by the same command.
- R4: With bits 20 and 21 both set, both live registers and both update pulses change in the same cycle.
- R5: With bits 20 and 21 both clear, the command changes only a staging buffer. No live code or mode changes and no update pulse fires. A later load shows the staged value.
- R6: Bit 19 has no effect on any output.
- R7: A command with bit 23 or bit 22 set changes no buffer and no live register, fires no update pulse, and raises the error output for exactly one cycle.
- R8: The live register, its update pulse and the error pulse all change at the first clock edge that samples cmdValid high. Each pulse lasts one cycle per accepted command.
- R9: Mode encoding: 00 is normal, 01 is low through about 1 kOhm, 10 is low through about 100 kOhm, and 11 is high impedance. A channel in power-down returns to 00 only when 00 is staged for that channel and the channel is then loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word is complete this cycle |
| cmdWord | input | 24 | Control byte (23:16) and code (15:0) |
| codeA | output | 16 | Live code, channel A |
| codeB | output | 16 | Live code, channel B |
| modeA | output | 2 | Live power mode, channel A |
| modeB | output | 2 | Live power mode, channel B |
| updA | output | 1 | One-cycle pulse when A's live register loads |
| updB | output | 1 | One-cycle pulse when B's live register loads |
| cmdErr | output | 1 | One-cycle pulse on a command with a reserved bit set |

## Verification
The bench targets five corner cases:
- Write-and-load in one command. A design that loaded the stale staging value would show the previous code.
- Staging with no load bits. A design that leaked this to the outputs would show early changes or spurious pulses.
- Reserved-bit commands, including ones that also carry load bits. A faulty design would corrupt a buffer or fire a load.
- Power-down exit. A design that cleared the mode on a bare data write would wake the channel too early.
- Toggling the don't-care bit.

Random commands with a shadow model then cover the mixed orderings.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  typedef struct packed {
    logic [NUM_CH-1:0] wrBuf;
    logic [NUM_CH-1:0] ldOut;
    logic              err;
  } ctrlStrobe_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MODE_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [DATA_W+MODE_W+5:0]   cmdWord,
  output ctrlStrobe_t                strobe
);
  localparam int SEL_BIT  = DATA_W + MODE_W;
  localparam int LD_A_BIT = SEL_BIT + 2;
  localparam int LD_B_BIT = SEL_BIT + 3;
  localparam int RSV_LO   = SEL_BIT + 4;
  localparam int RSV_HI   = SEL_BIT + 5;

  logic rsvHit;
  logic accept;

  always_comb begin
    rsvHit = |cmdWord[RSV_HI:RSV_LO];
    accept = cmdValid && !rsvHit;
    strobe.err          = cmdValid && rsvHit;
    strobe.wrBuf[CH_A]  = accept && !cmdWord[SEL_BIT];
    strobe.wrBuf[CH_B]  = accept &&  cmdWord[SEL_BIT];
    strobe.ldOut[CH_A]  = accept &&  cmdWord[LD_A_BIT];
    strobe.ldOut[CH_B]  = accept &&  cmdWord[LD_B_BIT];
  end

  AST_ONE_BUFFER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrBuf)); // R2
  AST_ERR_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.err |-> (strobe.wrBuf == '0) && (strobe.ldOut == '0)); // R7
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> !strobe.err && (strobe.ldOut == '0)); // R8
endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MODE_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strobe,
  input  logic [DATA_W-1:0]                 inCode,
  input  logic [MODE_W-1:0]                 inMode,
  output logic [NUM_CH-1:0][DATA_W-1:0]     liveCode,
  output logic [NUM_CH-1:0][MODE_W-1:0]     liveMode,
  output logic [NUM_CH-1:0]                 updPulse,
  output logic                              errPulse
);
  logic [NUM_CH-1:0][DATA_W-1:0] bufCode;
  logic [NUM_CH-1:0][MODE_W-1:0] bufMode;
  logic [NUM_CH-1:0][DATA_W-1:0] stageCode;
  logic [NUM_CH-1:0][MODE_W-1:0] stageMode;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      stageCode[ch] = strobe.wrBuf[ch] ? inCode : bufCode[ch];
      stageMode[ch] = strobe.wrBuf[ch] ? inMode : bufMode[ch];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufCode[ch]  <= '0;
        bufMode[ch]  <= '0;
        liveCode[ch] <= '0;
        liveMode[ch] <= '0;
        updPulse[ch] <= 1'b0;
      end else begin
        bufCode[ch]  <= stageCode[ch];
        bufMode[ch]  <= stageMode[ch];
        updPulse[ch] <= strobe.ldOut[ch];
        if (strobe.ldOut[ch]) begin
          liveCode[ch] <= stageCode[ch];
          liveMode[ch] <= stageMode[ch];
        end
      end
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.ldOut[ch] |=> $stable(liveCode[ch]) && $stable(liveMode[ch])); // R5
    AST_LOAD_PULSES: assert property (@(posedge clk) disable iff (!rstN)
      strobe.ldOut[ch] |=> updPulse[ch]); // R8
    AST_LOAD_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.ldOut[ch] && strobe.wrBuf[ch]) |=>
        (liveCode[ch] == $past(inCode)) && (liveMode[ch] == $past(inMode))); // R3
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= strobe.err;
  end

  AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.err |=> errPulse && (updPulse == '0)); // R7
endmodule

// File: rtl/dual_chan_regbank.sv
module dual_chan_regbank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MODE_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [DATA_W+MODE_W+5:0] cmdWord,
  output logic [DATA_W-1:0]        codeA,
  output logic [DATA_W-1:0]        codeB,
  output logic [MODE_W-1:0]        modeA,
  output logic [MODE_W-1:0]        modeB,
  output logic                     updA,
  output logic                     updB,
  output logic                     cmdErr
);
  ctrlStrobe_t                   strobe;
  logic [NUM_CH-1:0][DATA_W-1:0] liveCode;
  logic [NUM_CH-1:0][MODE_W-1:0] liveMode;
  logic [NUM_CH-1:0]             updPulse;

  regbank_ctrl #(.DATA_W(DATA_W), .MODE_W(MODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord), .strobe(strobe)
  );

  regbank_dp #(.DATA_W(DATA_W), .MODE_W(MODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inCode(cmdWord[DATA_W-1:0]),
    .inMode(cmdWord[DATA_W+MODE_W-1:DATA_W]),
    .liveCode(liveCode), .liveMode(liveMode),
    .updPulse(updPulse), .errPulse(cmdErr)
  );

  assign codeA = liveCode[CH_A];
  assign codeB = liveCode[CH_B];
  assign modeA = liveMode[CH_A];
  assign modeB = liveMode[CH_B];
  assign updA  = updPulse[CH_A];
  assign updB  = updPulse[CH_B];

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> (codeA == '0) && (codeB == '0) && (modeA == '0) && (modeB == '0)); // R1
endmodule

// File: tb/dual_chan_regbank_tb_top.sv
module dual_chan_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [23:0] cmdWord = '0;
  logic [15:0] codeA, codeB;
  logic [1:0]  modeA, modeB;
  logic        updA, updB, cmdErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [15:0] mBufCode [2];
  logic [1:0]  mBufMode [2];
  logic [15:0] mCode [2];
  logic [1:0]  mMode [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_chan_regbank dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .codeA(codeA), .codeB(codeB), .modeA(modeA), .modeB(modeB),
    .updA(updA), .updB(updB), .cmdErr(cmdErr)
  );

  function automatic logic [23:0] mkCmd(bit ldB, bit ldA, bit dc, bit sel,
                                        logic [1:0] pd, logic [15:0] data);
    return {2'b00, ldB, ldA, dc, sel, pd, data};
  endfunction

  function automatic bit isRejected(logic [23:0] w);
    return (w[23] || w[22]);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req, bit expUpdA, bit expUpdB, bit expErr);
    chk(req, "codeA", 32'(codeA), 32'(mCode[0]));
    chk(req, "codeB", 32'(codeB), 32'(mCode[1]));
    chk(req, "modeA", 32'(modeA), 32'(mMode[0]));
    chk(req, "modeB", 32'(modeB), 32'(mMode[1]));
    chk(req, "updA",  32'(updA),  32'(expUpdA));
    chk(req, "updB",  32'(updB),  32'(expUpdB));
    chk(req, "cmdErr", 32'(cmdErr), 32'(expErr));
  endtask

  // Drive one command for one cycle, update the model, check after the edge.
  task automatic sendCmd(logic [23:0] w, string req);
    bit ok, la, lb;
    int sel;
    ok = !isRejected(w);
    sel = w[18] ? 1 : 0;
    la = ok && w[20];
    lb = ok && w[21];
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = w;
    if (ok) begin
      mBufCode[sel] = w[15:0];
      mBufMode[sel] = w[17:16];
    end
    if (la) begin mCode[0] = mBufCode[0]; mMode[0] = mBufMode[0]; end
    if (lb) begin mCode[1] = mBufCode[1]; mMode[1] = mBufMode[1]; end
    @(negedge clk);
    cmdValid = 1'b0;
    cmdWord  = $urandom();
    checkAll(req, la, lb, !ok);
    @(negedge clk);
    chk(req, "pulse width updA", 32'(updA), 0);
    chk(req, "pulse width cmdErr", 32'(cmdErr), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EED);
    for (int i = 0; i < 2; i++) begin
      mBufCode[i] = '0; mBufMode[i] = '0; mCode[i] = '0; mMode[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", 0, 0, 0);

    // R5: stage A without load, outputs still zero
    sendCmd(mkCmd(0, 0, 0, 0, 2'b00, 16'hA5A5), "R5");
    // R3: load A alone shows staged value
    sendCmd(mkCmd(0, 1, 0, 1, 2'b00, 16'h1234), "R3");
    // R3: write B and load B in one command
    sendCmd(mkCmd(1, 0, 0, 1, 2'b00, 16'hBEEF), "R3");
    // R4: stage A, then write B and load both together
    sendCmd(mkCmd(0, 0, 0, 0, 2'b00, 16'h0F0F), "R2");
    sendCmd(mkCmd(1, 1, 0, 1, 2'b00, 16'hFFFF), "R4");
    // R6: don't-care bit set changes nothing compared with clear
    sendCmd(mkCmd(0, 1, 1, 0, 2'b00, 16'h7FFF), "R6");
    sendCmd(mkCmd(0, 0, 1, 1, 2'b00, 16'h8000), "R6");
    // R7: reserved bits with load bits present
    sendCmd(24'h800000 | mkCmd(1, 1, 0, 0, 2'b11, 16'h4444), "R7");
    sendCmd(24'h400000 | mkCmd(1, 1, 0, 1, 2'b01, 16'h5555), "R7");
    sendCmd(mkCmd(1, 1, 0, 1, 2'b00, 16'h8000), "R7");
    // R9: power down A to 1k, B to high impedance
    sendCmd(mkCmd(0, 1, 0, 0, 2'b01, 16'h0000), "R9");
    sendCmd(mkCmd(1, 0, 0, 1, 2'b11, 16'h0000), "R9");
    // R9: staging 00 without load keeps A powered down
    sendCmd(mkCmd(0, 0, 0, 0, 2'b00, 16'h2222), "R9");
    // R9: load brings A back to normal
    sendCmd(mkCmd(0, 1, 0, 1, 2'b10, 16'h3333), "R9");
    sendCmd(mkCmd(1, 0, 0, 0, 2'b00, 16'h0000), "R9");
    // R2: data bits stored even with nonzero mode
    sendCmd(mkCmd(1, 0, 0, 1, 2'b10, 16'hC3C3), "R2");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [23:0] w;
      w = 24'($urandom());
      if (($urandom() % 8) != 0) w[23:22] = 2'b00;
      sendCmd(w, "R8");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule